// File: doc/BRIEF.md
# Two-Contact Switch Position Latch

This block cleans up a changeover switch whose two contacts reach the chip on two separate pins. Each pin idles high through a pull-up and is grounded while the arm touches that contact. Because the arm can only touch one contact at a time, the two pins act as set and reset commands for one stored bit. That bit is the switch position, and it is free of bounce without any timer.

Both pins are asynchronous to the system clock, so each passes through its own flop synchronizer first. Once the pins are in the clock domain, the high-side contact sets the position and the low-side contact clears it. While the arm is in transit, or has bounced open on the contact it just reached, the position holds its last value. Seeing both contacts made at once is a wiring or switch fault: the position then holds, and a fault flag stays raised until reset. A one-cycle pulse marks every change of position.

Top module: `spdt_latch`

## Requirements
- R1: While rst_ni is low, pos_o equals the INIT_POS parameter (default 0), change_o is 0 and fault_o is 0.
- R2: When pole_hi_ni is 0 and pole_lo_ni is 1 for at least one clock cycle, pos_o becomes 1. The new value appears after SYNC_STAGES+1 rising clock edges (3 edges at the default).
- R3: When pole_lo_ni is 0 and pole_hi_ni is 1 for at least one clock cycle, pos_o becomes 0, with the same latency as R2.
- R4: While both pole_hi_ni and pole_lo_ni are 1, pos_o keeps its previous value.
- R5: Bounce on the contact just reached changes pos_o only once. Here bounce means the active pole toggling between 0 and 1 while the other pole stays 1. It gives exactly one change_o pulse.
- R6: When both pole_hi_ni and pole_lo_ni are 0 in the same cycle, pos_o keeps its previous value and fault_o becomes 1.
- R7: change_o is 1 for exactly the one cycle in which pos_o takes a new value and is 0 in every other cycle. A repeated command for the position already held gives no pulse.
- R8: Once set, fault_o stays 1 through later legal inputs until rst_ni goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pole_hi_ni | input | 1 | High-side contact, 0 while made (pulled up) |
| pole_lo_ni | input | 1 | Low-side contact, 0 while made (pulled up) |
| pos_o | output | 1 | Clean switch position, 1 = high side |
| change_o | output | 1 | One-cycle pulse on each position change |
| fault_o | output | 1 | Sticky flag: both contacts seen made together |

## Verification
Every result is registered behind the synchronizer, so pos_o, change_o and fault_o all respond on the third rising edge after a pin changes. The bench changes the pins on a falling edge and reads the outputs on the third falling edge that follows. It expects change_o high at exactly that sample and low at the next one. For bounce trains, change_o is read on every falling edge across the whole train plus the pipeline drain, and the pulses are counted.

// File: rtl/spdt_pkg.sv
package spdt_pkg;
  typedef enum logic {
    POS_LO = 1'b0,
    POS_HI = 1'b1
  } pos_e;

  typedef struct packed {
    logic set;
    logic clr;
    logic conflict;
  } cmd_t;
endpackage

// File: rtl/spdt_sync.sv
module spdt_sync #(
  parameter int unsigned        WIDTH     = 2,
  parameter int unsigned        STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RESET_VAL[b]}};
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spdt_decode.sv
module spdt_decode
  import spdt_pkg::*;
(
  input  logic hi_ni,
  input  logic lo_ni,
  output cmd_t cmd_o
);
  always_comb begin
    cmd_o.set      = !hi_ni && lo_ni;
    cmd_o.clr      = hi_ni && !lo_ni;
    cmd_o.conflict = !hi_ni && !lo_ni;
  end
endmodule

// File: rtl/spdt_state.sv
module spdt_state
  import spdt_pkg::*;
#(
  parameter pos_e INIT_POS = POS_LO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_t cmd_i,
  output logic pos_o,
  output logic change_o,
  output logic fault_o
);
  pos_e pos_q, pos_d;
  logic chg_q, flt_q;

  always_comb begin
    pos_d = pos_q;
    if (cmd_i.set)      pos_d = POS_HI;
    else if (cmd_i.clr) pos_d = POS_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= INIT_POS;
      chg_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      chg_q <= (pos_d != pos_q);
      flt_q <= flt_q | cmd_i.conflict;
    end
  end

  assign pos_o    = pos_q;
  assign change_o = chg_q;
  assign fault_o  = flt_q;
endmodule

// File: rtl/spdt_latch.sv
module spdt_latch
  import spdt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter pos_e        INIT_POS    = POS_LO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pole_hi_ni,
  input  logic pole_lo_ni,
  output logic pos_o,
  output logic change_o,
  output logic fault_o
);
  localparam int unsigned NUM_POLES = 2;

  logic [NUM_POLES-1:0] raw_n, sync_n;
  logic hi_sync_n, lo_sync_n;
  cmd_t cmd;

  assign raw_n = {pole_hi_ni, pole_lo_ni};

  // idle value of each pin is high (pull-up)
  spdt_sync #(
    .WIDTH    (NUM_POLES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({NUM_POLES{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_n),
    .q_o   (sync_n)
  );

  assign hi_sync_n = sync_n[1];
  assign lo_sync_n = sync_n[0];

  spdt_decode u_decode (
    .hi_ni(hi_sync_n),
    .lo_ni(lo_sync_n),
    .cmd_o(cmd)
  );

  spdt_state #(
    .INIT_POS(INIT_POS)
  ) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .pos_o   (pos_o),
    .change_o(change_o),
    .fault_o (fault_o)
  );
endmodule

// File: rtl/spdt_latch_chk.sv
module spdt_latch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hi_s_n,
  input logic lo_s_n,
  input logic pos_o,
  input logic change_o,
  input logic fault_o
);
  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_s_n && lo_s_n) |=> pos_o);

  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_s_n && !lo_s_n) |=> !pos_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_s_n && lo_s_n) |=> $stable(pos_o));

  assert_conflict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_s_n && !lo_s_n) |=> ($stable(pos_o) && fault_o));

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (change_o == (pos_o != $past(pos_o))));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);
endmodule

bind spdt_latch spdt_latch_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hi_s_n  (hi_sync_n),
  .lo_s_n  (lo_sync_n),
  .pos_o   (pos_o),
  .change_o(change_o),
  .fault_o (fault_o)
);

// File: tb/spdt_latch_bench.sv
module spdt_latch_bench;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_n = 1'b1;
  logic lo_n = 1'b1;
  logic pos, change, fault;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spdt_latch u_spdt_latch (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pole_hi_ni(hi_n),
    .pole_lo_ni(lo_n),
    .pos_o     (pos),
    .change_o  (change),
    .fault_o   (fault)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic h, input logic l);
    hi_n = h;
    lo_n = l;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1, 1);
    step(3);
    check("R1 pos", pos, 0);
    check("R1 change", change, 0);
    check("R1 fault", fault, 0);
    rst_n = 1'b1;
    step(4);
    check("R1 pos after release", pos, 0);
  endtask

  task automatic t_set();
    drive(0, 1);
    step(LAT - 1);
    check("R2 not before latency", pos, 0);
    step(1);
    check("R2 pos", pos, 1);
    check("R7 pulse", change, 1);
    step(1);
    check("R7 pulse ends", change, 0);
    drive(1, 1);
    step(6);
    check("R4 hold high", pos, 1);
    check("R7 no pulse on hold", change, 0);
  endtask

  task automatic t_repeat_set();
    int pulses = 0;
    drive(0, 1);
    for (int i = 0; i < 6; i++) begin
      step(1);
      pulses += change;
    end
    drive(1, 1);
    step(4);
    check("R7 no pulse on repeat set", pulses, 0);
    check("R2 still high", pos, 1);
  endtask

  task automatic t_clear();
    drive(1, 0);
    step(LAT);
    check("R3 pos", pos, 0);
    check("R7 pulse clr", change, 1);
    drive(1, 1);
    step(1);
    check("R7 pulse ends clr", change, 0);
    step(5);
    check("R4 hold low", pos, 0);
  endtask

  task automatic t_single_cycle();
    drive(0, 1);
    step(1);
    drive(1, 1);
    step(LAT - 1);
    check("R2 one-cycle set", pos, 1);
    step(4);
    check("R4 hold after glitch", pos, 1);
    drive(1, 0);
    step(1);
    drive(1, 1);
    step(LAT - 1);
    check("R3 one-cycle clear", pos, 0);
  endtask

  task automatic t_bounce(input logic to_hi);
    int pulses = 0;
    for (int i = 0; i < 12; i++) begin
      if (to_hi) drive(((i % 3) == 1), 1);
      else drive(1, ((i % 2) == 1));
      step(1);
      pulses += change;
    end
    drive(to_hi ? 1'b0 : 1'b1, to_hi ? 1'b1 : 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1);
      pulses += change;
    end
    drive(1, 1);
    step(4);
    check(to_hi ? "R5 bounce hi pulses" : "R5 bounce lo pulses", pulses, 1);
    check(to_hi ? "R5 bounce hi pos" : "R5 bounce lo pos", pos, to_hi);
  endtask

  task automatic t_conflict();
    drive(0, 0);
    step(LAT);
    check("R6 hold on conflict", pos, 1);
    check("R6 fault", fault, 1);
    check("R6 no pulse", change, 0);
    drive(1, 0);
    step(LAT + 2);
    check("R3 clear after fault", pos, 0);
    check("R8 sticky", fault, 1);
    drive(1, 1);
    step(3);
    rst_n = 1'b0;
    step(1);
    check("R8 cleared by reset", fault, 0);
    rst_n = 1'b1;
    step(2);
  endtask

  initial begin
    step(1);
    t_reset();
    t_set();
    t_repeat_set();
    t_clear();
    t_single_cycle();
    t_bounce(1'b1);
    t_bounce(1'b0);
    drive(0, 1);
    step(LAT + 1);
    drive(1, 1);
    step(2);
    t_conflict();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule